// File: doc/BRIEF.md
# Quadrature Motion Accumulator and Report Builder

This block turns two pairs of quadrature photo-sensor levels and three button levels into the three-byte movement report of a serial pointing device. Every sensor pin passes through a synchronizer and a minimum-width filter, so short noise pulses that appear when a slotted wheel sits half-open never reach the decoder. The filtered pairs are decoded into signed, saturating X and Y counts. The three buttons pass through the same filter structure with a much longer hold time, which debounces both press and release.

A command processor drives the sample-interval tick and the mode flags. At each tick in stream mode with reporting enabled, the block latches a report if a button changed since the last latched report or if any movement or overflow has built up. It then raises `report_due`. A read request latches a report at once whatever the activity. The command processor sends the held bytes and pulses `report_done`. That pulse drops `report_due` and clears the counts. An optional speed curve reshapes the count magnitudes of stream reports.

Top module: `motion_report_unit`

## Requirements
- R1: Each pin pair is decoded with the state code {a,b}. The forward cycle is 00→10→11→01→00, and each forward step adds 1 to that axis count. Each step in the reverse cycle subtracts 1. A change of both pins at once is ignored.
- R2: A sensor pin change takes effect only after the new level has been seen at the synchronizer output for SENSOR_HOLD_CYC consecutive clocks. A shorter pulse leaves the counts unchanged.
- R3: A button press or release is accepted only after the new level has held for KEY_HOLD_CYC consecutive clocks. Shorter presses or bounces are ignored.
- R4: `rpt_status` holds left in bit 0, right in bit 1, middle in bit 2, a constant 1 in bit 3, the X sign in bit 4, the Y sign in bit 5, X overflow in bit 6 and Y overflow in bit 7. `rpt_dx` and `rpt_dy` hold the low 8 bits of the reported 9-bit two's-complement values.
- R5: Each count is 9-bit two's complement and saturates at +255 and -256. A step beyond either limit leaves the count unchanged and sets that axis's overflow flag.
- R6: A tick latches a report and raises `report_due` only when stream mode and reporting are both on, no report is pending, and there is activity. Activity means a debounced button differs from the last latched set, or a count is nonzero, or an overflow flag is set.
- R7: With the speed curve on, a stream report maps each magnitude as 0→0, 1→1, 2→1, 3→3, 4→6, 5→9 and N≥6→2N, and keeps the sign. A result beyond +255 or -256 is clipped to that limit and sets the axis overflow bit.
- R8: `read_req` latches a report and raises `report_due` in any mode, with or without activity, and never applies the speed curve.
- R9: While `report_due` is high the report bytes hold still. A `report_done` pulse drops `report_due` and clears both counts and both overflow flags.
- R10: After a report has latched a button set, a later tick with the same buttons and no movement raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qx_a | input | 1 | X sensor, first phase |
| qx_b | input | 1 | X sensor, second phase |
| qy_a | input | 1 | Y sensor, first phase |
| qy_b | input | 1 | Y sensor, second phase |
| btn_left | input | 1 | Left button, 1 = pressed |
| btn_mid | input | 1 | Middle button, 1 = pressed |
| btn_right | input | 1 | Right button, 1 = pressed |
| sample_tick | input | 1 | One-clock pulse at the end of each sample interval |
| stream_mode | input | 1 | 1 = stream mode, 0 = remote mode |
| report_en | input | 1 | Stream reporting enabled |
| autospeed_en | input | 1 | Speed curve enabled |
| read_req | input | 1 | One-clock pulse requesting an unconditional report |
| report_done | input | 1 | One-clock pulse: held report consumed, clear counts |
| report_due | output | 1 | A latched report waits to be sent |
| rpt_status | output | 8 | Report byte 1: buttons, signs, overflow |
| rpt_dx | output | 8 | Report byte 2: X movement |
| rpt_dy | output | 8 | Report byte 3: Y movement |

## Verification
The hardest states to reach from the ports are the saturation and clipping edges. Reaching +255, -256 or a clipped speed-curve value takes hundreds of clean quadrature steps. Each step must outlast the synchronizer and the hold filter. The bench walks the pin pairs through the state code with a fixed settle time per step and keeps its own saturating model, so any step count gives arithmetic expected bytes. Glitch and bounce pulses are timed one clock shorter than the hold window, because the synchronizer keeps pulse width unchanged.

// File: rtl/mrep_pkg.sv
`timescale 1ns/1ps
package mrep_pkg;
    // Report format fixes the count width: 8 data bits plus a sign.
    localparam int CNT_W   = 9;
    localparam int BYTE_W  = CNT_W - 1;
    localparam int NUM_KEY = 3;

    typedef struct packed {
        logic [7:0] status;
        logic [7:0] dx;
        logic [7:0] dy;
    } rpt_t;

    typedef struct packed {
        logic             clip;
        logic [CNT_W-1:0] val;
    } shaped_t;
endpackage

// File: rtl/mrep_glitch_filter.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by a run-length filter: the output follows
// the input only after HOLD consecutive clocks of a differing level.
module mrep_glitch_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int RW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [RW-1:0] LAST = RW'(HOLD - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [RW-1:0] run;
    } flt_t;

    flt_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], raw};
        if (s_q.sync[1] == s_q.lvl) begin
            s_d.run = '0;
        end else if (s_q.run == LAST) begin
            s_d.lvl = s_q.sync[1];
            s_d.run = '0;
        end else begin
            s_d.run = s_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clean = s_q.lvl;
endmodule

// File: rtl/mrep_quad_axis.sv
`timescale 1ns/1ps
// One axis: filter both phases, decode quadrature steps, keep a saturating
// two's-complement count with a sticky overflow flag.
module mrep_quad_axis
    import mrep_pkg::*;
#(
    parameter int HOLD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] BOT = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic [1:0]       prev;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } axis_t;

    axis_t s_q, s_d;
    logic  fa, fb;
    logic [1:0] cur;
    logic fwd, bwd;
    logic [CNT_W-1:0] base_cnt;
    logic base_ovf;

    for (genvar p = 0; p < 2; p++) begin : g_phase
        if (p == 0) begin : g_a
            mrep_glitch_filter #(.HOLD(HOLD)) u_flt (
                .clk(clk), .rst_n(rst_n), .raw(pin_a), .clean(fa));
        end else begin : g_b
            mrep_glitch_filter #(.HOLD(HOLD)) u_flt (
                .clk(clk), .rst_n(rst_n), .raw(pin_b), .clean(fb));
        end
    end

    assign cur = {fa, fb};

    always_comb begin
        fwd = ((s_q.prev == 2'b00) && (cur == 2'b10)) ||
              ((s_q.prev == 2'b10) && (cur == 2'b11)) ||
              ((s_q.prev == 2'b11) && (cur == 2'b01)) ||
              ((s_q.prev == 2'b01) && (cur == 2'b00));
        bwd = ((s_q.prev == 2'b10) && (cur == 2'b00)) ||
              ((s_q.prev == 2'b11) && (cur == 2'b10)) ||
              ((s_q.prev == 2'b01) && (cur == 2'b11)) ||
              ((s_q.prev == 2'b00) && (cur == 2'b01));
        base_cnt = clear ? '0 : s_q.cnt;
        base_ovf = clear ? 1'b0 : s_q.ovf;

        s_d      = s_q;
        s_d.prev = cur;
        s_d.cnt  = base_cnt;
        s_d.ovf  = base_ovf;
        if (fwd) begin
            if (base_cnt == TOP) s_d.ovf = 1'b1;
            else                 s_d.cnt = base_cnt + 1'b1;
        end else if (bwd) begin
            if (base_cnt == BOT) s_d.ovf = 1'b1;
            else                 s_d.cnt = base_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
    assign ovf   = s_q.ovf;
endmodule

// File: rtl/mrep_report_build.sv
`timescale 1ns/1ps
// Combinational report assembly with the optional magnitude speed curve.
module mrep_report_build
    import mrep_pkg::*;
(
    input  logic [CNT_W-1:0]   cnt_x,
    input  logic [CNT_W-1:0]   cnt_y,
    input  logic               ovf_x,
    input  logic               ovf_y,
    input  logic [NUM_KEY-1:0] keys,     // {middle, right, left}
    input  logic               speed_on,
    output rpt_t               rpt
);
    localparam int MW = CNT_W + 1;
    localparam logic [MW-1:0] NEG_LIM = MW'(1) << (CNT_W - 1);
    localparam logic [MW-1:0] POS_LIM = NEG_LIM - 1'b1;

    function automatic logic [MW-1:0] curve(input logic [MW-1:0] m);
        case (m)
            MW'(0):  curve = MW'(0);
            MW'(1):  curve = MW'(1);
            MW'(2):  curve = MW'(1);
            MW'(3):  curve = MW'(3);
            MW'(4):  curve = MW'(6);
            MW'(5):  curve = MW'(9);
            default: curve = m << 1;
        endcase
    endfunction

    function automatic shaped_t shape(input logic [CNT_W-1:0] v, input logic spd);
        logic          neg;
        logic [MW-1:0] mag, c, lim, res;
        neg = v[CNT_W-1];
        mag = neg ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
        c   = spd ? curve(mag) : mag;
        lim = neg ? NEG_LIM : POS_LIM;
        shape.clip = (c > lim);
        if (c > lim) c = lim;
        res = neg ? (~c + 1'b1) : c;
        shape.val = res[CNT_W-1:0];
    endfunction

    shaped_t sx, sy;

    always_comb begin
        sx = shape(cnt_x, speed_on);
        sy = shape(cnt_y, speed_on);
        rpt.status = {ovf_y | sy.clip, ovf_x | sx.clip,
                      sy.val[CNT_W-1], sx.val[CNT_W-1],
                      1'b1, keys[2], keys[1], keys[0]};
        rpt.dx = sx.val[BYTE_W-1:0];
        rpt.dy = sy.val[BYTE_W-1:0];
    end
endmodule

// File: rtl/motion_report_unit.sv
`timescale 1ns/1ps
module motion_report_unit
    import mrep_pkg::*;
#(
    parameter int SENSOR_HOLD_CYC = 15,
    parameter int KEY_HOLD_CYC    = 12000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qx_a,
    input  logic       qx_b,
    input  logic       qy_a,
    input  logic       qy_b,
    input  logic       btn_left,
    input  logic       btn_mid,
    input  logic       btn_right,
    input  logic       sample_tick,
    input  logic       stream_mode,
    input  logic       report_en,
    input  logic       autospeed_en,
    input  logic       read_req,
    input  logic       report_done,
    output logic       report_due,
    output logic [7:0] rpt_status,
    output logic [7:0] rpt_dx,
    output logic [7:0] rpt_dy
);
    typedef struct packed {
        logic               due;
        rpt_t               rpt;
        logic [NUM_KEY-1:0] last_keys;
    } top_t;

    top_t s_q, s_d;

    logic [CNT_W-1:0]   cnt_x, cnt_y;
    logic               ovf_x, ovf_y;
    logic [NUM_KEY-1:0] keys_raw, keys;
    logic               speed_on, activity, stream_fire;
    rpt_t               built;

    mrep_quad_axis #(.HOLD(SENSOR_HOLD_CYC)) u_axis_x (
        .clk(clk), .rst_n(rst_n), .pin_a(qx_a), .pin_b(qx_b),
        .clear(report_done), .count(cnt_x), .ovf(ovf_x));

    mrep_quad_axis #(.HOLD(SENSOR_HOLD_CYC)) u_axis_y (
        .clk(clk), .rst_n(rst_n), .pin_a(qy_a), .pin_b(qy_b),
        .clear(report_done), .count(cnt_y), .ovf(ovf_y));

    assign keys_raw = {btn_mid, btn_right, btn_left};

    for (genvar k = 0; k < NUM_KEY; k++) begin : g_key
        mrep_glitch_filter #(.HOLD(KEY_HOLD_CYC)) u_deb (
            .clk(clk), .rst_n(rst_n), .raw(keys_raw[k]), .clean(keys[k]));
    end

    assign speed_on = autospeed_en & stream_mode & ~read_req;

    mrep_report_build u_build (
        .cnt_x(cnt_x), .cnt_y(cnt_y), .ovf_x(ovf_x), .ovf_y(ovf_y),
        .keys(keys), .speed_on(speed_on), .rpt(built));

    always_comb begin
        activity    = (keys != s_q.last_keys) || (cnt_x != '0) ||
                      (cnt_y != '0) || ovf_x || ovf_y;
        stream_fire = sample_tick && stream_mode && report_en &&
                      activity && !s_q.due;
        s_d = s_q;
        if (report_done) s_d.due = 1'b0;
        if (read_req || stream_fire) begin
            s_d.due       = 1'b1;
            s_d.rpt       = built;
            s_d.last_keys = keys;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign report_due = s_q.due;
    assign rpt_status = s_q.rpt.status;
    assign rpt_dx     = s_q.rpt.dx;
    assign rpt_dy     = s_q.rpt.dy;
endmodule

// File: rtl/motion_report_chk.sv
`timescale 1ns/1ps
module motion_report_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_tick,
    input logic       stream_mode,
    input logic       report_en,
    input logic       read_req,
    input logic       report_done,
    input logic       report_due,
    input logic [7:0] rpt_status,
    input logic [7:0] rpt_dx,
    input logic [7:0] rpt_dy
);
    // R6
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick && !read_req && !(stream_mode && report_en) |=> !$rose(report_due));

    // R6
    due_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(report_due) |-> $past(sample_tick || read_req));

    // R8
    read_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |=> report_due);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        report_done && !read_req && !sample_tick |=> !report_due);

    // R9
    hold_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        report_due && !report_done && !read_req |=> $stable({rpt_status, rpt_dx, rpt_dy}));

    // R4
    fixed_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        report_due |-> rpt_status[3]);
endmodule

bind motion_report_unit motion_report_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .stream_mode(stream_mode), .report_en(report_en), .read_req(read_req),
    .report_done(report_done), .report_due(report_due),
    .rpt_status(rpt_status), .rpt_dx(rpt_dx), .rpt_dy(rpt_dy));

// File: tb/motion_report_unit_test.sv
`timescale 1ns/1ps
module motion_report_unit_test;
    localparam int SH = 4;
    localparam int DH = 12;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, qx_a, qx_b, qy_a, qy_b, btn_left, btn_mid, btn_right;
    logic sample_tick, stream_mode, report_en, autospeed_en, read_req, report_done;
    logic report_due;
    logic [7:0] rpt_status, rpt_dx, rpt_dy;

    motion_report_unit #(.SENSOR_HOLD_CYC(SH), .KEY_HOLD_CYC(DH)) uut (
        .clk(clk), .rst_n(rst_n), .qx_a(qx_a), .qx_b(qx_b), .qy_a(qy_a), .qy_b(qy_b),
        .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right),
        .sample_tick(sample_tick), .stream_mode(stream_mode), .report_en(report_en),
        .autospeed_en(autospeed_en), .read_req(read_req), .report_done(report_done),
        .report_due(report_due), .rpt_status(rpt_status), .rpt_dx(rpt_dx), .rpt_dy(rpt_dy));

    int checks = 0, fails = 0;
    int xi = 0, yi = 0, mx = 0, my = 0;
    bit ox = 0, oy = 0, bl = 0, bm = 0, br = 0;

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] enc(int i);
        case (i)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic int curve(int m);
        if (m == 0) return 0;
        if (m <= 2) return 1;
        if (m <= 5) return 3 * (m - 2);
        return 2 * m;
    endfunction

    task automatic step(bit ax, int dir);
        if (!ax) begin
            xi = (xi + dir + 4) % 4;
            {qx_a, qx_b} = enc(xi);
            if (dir > 0) begin if (mx == 255) ox = 1; else mx++; end
            else begin if (mx == -256) ox = 1; else mx--; end
        end else begin
            yi = (yi + dir + 4) % 4;
            {qy_a, qy_b} = enc(yi);
            if (dir > 0) begin if (my == 255) oy = 1; else my++; end
            else begin if (my == -256) oy = 1; else my--; end
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic move(int nx, int ny);
        for (int i = 0; i < (nx < 0 ? -nx : nx); i++) step(0, nx < 0 ? -1 : 1);
        for (int i = 0; i < (ny < 0 ? -ny : ny); i++) step(1, ny < 0 ? -1 : 1);
    endtask

    task automatic tick();
        sample_tick = 1'b1; @(negedge clk); sample_tick = 1'b0; @(negedge clk);
    endtask

    task automatic rd();
        read_req = 1'b1; @(negedge clk); read_req = 1'b0; @(negedge clk);
    endtask

    task automatic done();
        report_done = 1'b1; @(negedge clk); report_done = 1'b0; @(negedge clk);
        mx = 0; my = 0; ox = 0; oy = 0;
    endtask

    task automatic expect_rpt(string tag, bit spd);
        int vx, vy;
        bit cx, cy;
        logic [8:0] tx, ty;
        cx = 0; cy = 0; vx = mx; vy = my;
        if (spd) begin
            vx = (mx < 0) ? -curve(-mx) : curve(mx);
            vy = (my < 0) ? -curve(-my) : curve(my);
        end
        if (vx > 255) begin vx = 255; cx = 1; end
        if (vx < -256) begin vx = -256; cx = 1; end
        if (vy > 255) begin vy = 255; cy = 1; end
        if (vy < -256) begin vy = -256; cy = 1; end
        tx = 9'(vx); ty = 9'(vy);
        chk8({tag, " due"}, {7'd0, report_due}, 8'd1);
        chk8({tag, " status"}, rpt_status,
             {oy | cy, ox | cx, ty[8], tx[8], 1'b1, bm, br, bl});
        chk8({tag, " dx"}, rpt_dx, tx[7:0]);
        chk8({tag, " dy"}, rpt_dy, ty[7:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; {qx_a, qx_b, qy_a, qy_b} = '0; {btn_left, btn_mid, btn_right} = '0;
        sample_tick = 0; stream_mode = 0; report_en = 0; autospeed_en = 0;
        read_req = 0; report_done = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk8("R6 reset due", {7'd0, report_due}, 8'd0);

        // R1 R4 R8: both directions on both axes, remote read
        for (int n = 0; n < 12; n++) begin
            move(n, 5 - n);
            rd();
            expect_rpt("R1 R4 R8 sweep", 0);
            done();
        end

        // R1: both pins changing together are ignored
        {qx_a, qx_b} = enc((xi + 2) % 4); repeat (10) @(negedge clk);
        {qx_a, qx_b} = enc(xi);           repeat (10) @(negedge clk);
        rd(); expect_rpt("R1 double change", 0); done();

        // R2: pulses one clock shorter than the hold window
        qx_a = ~qx_a; repeat (SH - 1) @(negedge clk); qx_a = ~qx_a;
        repeat (10) @(negedge clk);
        qy_b = ~qy_b; repeat (SH - 1) @(negedge clk); qy_b = ~qy_b;
        repeat (10) @(negedge clk);
        rd(); expect_rpt("R2 glitch", 0); done();
        step(0, 1); step(1, -1);
        rd(); expect_rpt("R2 held step", 0); done();

        // R5: saturation at both limits
        move(255, 0);
        rd(); expect_rpt("R5 at top", 0); done();
        move(258, -259);
        rd(); expect_rpt("R5 saturated", 0); done();

        // R6 R7: stream reports with the speed curve
        stream_mode = 1; report_en = 1; autospeed_en = 1;
        for (int n = 0; n < 14; n++) begin
            move(n, -n);
            tick();
            if (n == 0) chk8("R6 idle tick", {7'd0, report_due}, 8'd0);
            else        expect_rpt("R6 R7 curve", 1);
            done();
        end
        move(130, -130);
        tick(); expect_rpt("R7 clip", 1); done();

        // R8: read request bypasses the curve
        move(4, -5);
        rd(); expect_rpt("R8 no curve", 0); done();

        // R6: gating by enable and mode
        autospeed_en = 0; report_en = 0;
        move(3, 0);
        tick(); chk8("R6 disabled", {7'd0, report_due}, 8'd0);
        rd(); expect_rpt("R8 while disabled", 0); done();
        report_en = 1; stream_mode = 0;
        move(2, 0);
        tick(); chk8("R6 remote tick", {7'd0, report_due}, 8'd0);
        rd(); expect_rpt("R8 remote", 0); done();
        stream_mode = 1;

        // R3 R10: button debounce and change detection
        btn_left = 1; repeat (DH - 1) @(negedge clk); btn_left = 0;
        repeat (DH + 6) @(negedge clk);
        tick(); chk8("R3 short press", {7'd0, report_due}, 8'd0);
        btn_left = 1; bl = 1; repeat (DH + 6) @(negedge clk);
        tick(); expect_rpt("R3 press", 0); done();
        tick(); chk8("R10 unchanged keys", {7'd0, report_due}, 8'd0);
        btn_left = 0; repeat (DH - 1) @(negedge clk); btn_left = 1;
        repeat (DH + 6) @(negedge clk);
        tick(); chk8("R3 release bounce", {7'd0, report_due}, 8'd0);
        btn_left = 0; bl = 0; btn_mid = 1; bm = 1; btn_right = 1; br = 1;
        repeat (DH + 6) @(negedge clk);
        tick(); expect_rpt("R3 R4 release and others", 0); done();

        // R9: held bytes frozen, counts cleared by done
        move(3, 0);
        rd(); expect_rpt("R9 latch", 0);
        move(2, 0);
        tick();
        chk8("R9 frozen dx", rpt_dx, 8'd3);
        chk8("R9 still due", {7'd0, report_due}, 8'd1);
        done();
        chk8("R9 due cleared", {7'd0, report_due}, 8'd0);
        rd(); expect_rpt("R9 counts cleared", 0); done();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule